// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block changes the divider setting of one PLL without passing an unstable clock downstream. A request carries the reference divider, the feedback divider and the output divider. The sequencer first checks that the request is legal. It then moves the PLL output mux to the bypass oscillator and puts the PLL into reset. While reset is held it writes the stored divider fields and the bandwidth-adjust field. It keeps reset asserted for a fixed settle time, releases it, and polls the lock input about once per microsecond. After lock is seen it moves the mux back to the PLL. If lock does not arrive within a bounded number of polls, the sequencer flags a timeout and leaves the output on the oscillator.

The block also gives a registered estimate of the current output frequency, worked out from the mode and the divider image. A separate input can park the output in a low-power deep mode, which reports a 32768 Hz clock.

Top module: `pll_reprog_seq`

## Requirements
- R1: While reset is applied and right after it: `pll_mode` is slow (encoding 0 = slow, 1 = normal, 2 = deep), `pll_reset`, `busy`, `done`, `err_reject` and `err_timeout` are low, and `rate_hz` is the oscillator rate of 24000000.
- R2: A request made while idle is rejected if any of these is true: nr, nf or no is 0; no is greater than 16; no is odd and not 1; or the VCO frequency 24 MHz·nf/nr lies outside 440–2200 MHz (inclusive bounds); or the output frequency VCO/no is below 27.5 MHz. On a rejection, one clock edge later `done` and `err_reject` are high for one cycle, `busy` stays low, and the mode and the register image do not change.
- R3: A legal request sets `busy` and slow mode at the next edge. `pll_reset` rises one edge later.
- R4: While `pll_reset` is high, the image holds `cfg_nr_m1` = nr−1, `cfg_nf_m1` = nf−1 (13 bits), `cfg_no_m1` = no−1 (4 bits) and `cfg_bwadj` = (nf>>1)−1 (12 bits). The image changes only while `pll_reset` is high.
- R5: `pll_reset` stays high for exactly SETTLE_CYC+1 cycles, where SETTLE_CYC = CLK_HZ/100000 is 10 µs. Only the last SETTLE_CYC of those cycles come after the fields are loaded.
- R6: After reset is released, the lock input is sampled every POLL_CYC = CLK_HZ/1000000 cycles. The first sample that sees lock high sets normal mode, drops `busy` and pulses `done`. The mode never becomes normal unless lock was high at the edge before.
- R7: If LOCK_POLLS samples in a row see no lock, `done` and `err_timeout` pulse, `busy` drops, and the mode stays slow.
- R8: Requests that arrive while `busy` is high are ignored: the image at completion matches the accepted request.
- R9: `rate_hz` follows the mode one cycle later. Slow gives 24000000, deep gives 32768, and normal gives floor(24000000·nf/(nr·no)) using the stored fields.
- R10: While idle with no request, `deep_en` high moves the mode to deep. Deep with `deep_en` low returns to slow. A request accepted in deep mode goes through slow as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, acted on only while idle |
| req_nr | input | NR_W | Reference divider value |
| req_nf | input | NF_W | Feedback divider value |
| req_no | input | OD_W+1 | Output divider value |
| deep_en | input | 1 | Ask for deep mode while idle |
| pll_lock | input | 1 | Lock indication from the PLL |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_reject | output | 1 | With done: request was illegal |
| err_timeout | output | 1 | With done: lock never arrived |
| pll_mode | output | 2 | Output mux mode: 0 slow, 1 normal, 2 deep |
| pll_reset | output | 1 | PLL reset control |
| cfg_nr_m1 | output | NR_W | Stored reference divider minus one |
| cfg_nf_m1 | output | NF_W | Stored feedback divider minus one |
| cfg_no_m1 | output | OD_W | Stored output divider minus one |
| cfg_bwadj | output | NF_W-1 | Bandwidth adjust, (nf>>1)-1 |
| rate_hz | output | 32 | Current output frequency estimate in Hz |

## Verification
If the sequencer is in the wrong state, the ports show it early. `pll_reset` rises or falls one or more cycles away from the exact settle window, or the mode goes to normal on a poll that did not see lock. These are visible in the cycle they happen. A wrong divider image or bandwidth value shows while reset is high, and in `rate_hz` one cycle after the mode changes. A wrong poll counter moves the `done` edge off the expected multiple of the poll period, either when lock arrives or at the timeout.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [1:0] {
    MODE_SLOW   = 2'd0,
    MODE_NORMAL = 2'd1,
    MODE_DEEP   = 2'd2
  } pll_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,
    ST_LOAD,
    ST_SETTLE,
    ST_POLL
  } seq_state_e;
endpackage

// File: rtl/pll_req_check.sv
module pll_req_check #(
  parameter int NR_W        = 6,
  parameter int NF_W        = 13,
  parameter int OD_W        = 4,
  parameter int REF_KHZ     = 24000,
  parameter int VCO_MIN_KHZ = 440000,
  parameter int VCO_MAX_KHZ = 2200000,
  parameter int OUT_MIN_KHZ = 27500
) (
  input  logic [NR_W-1:0] nr,
  input  logic [NF_W-1:0] nf,
  input  logic [OD_W:0]   no,
  output logic            ok
);
  localparam int MAX_NO = 1 << OD_W;

  logic [63:0] ref_term, vmin_term, vmax_term, omin_term;
  logic        no_ok, vco_ok, out_ok;

  always_comb begin
    ref_term  = 64'(REF_KHZ) * 64'(nf);
    vmin_term = 64'(VCO_MIN_KHZ) * 64'(nr);
    vmax_term = 64'(VCO_MAX_KHZ) * 64'(nr);
    omin_term = 64'(OUT_MIN_KHZ) * 64'(nr) * 64'(no);
    no_ok     = (no != '0) && (32'(no) <= MAX_NO) && ((no == 1) || !no[0]);
    vco_ok    = (ref_term >= vmin_term) && (ref_term <= vmax_term);
    out_ok    = ref_term >= omin_term;
    ok        = (nr != '0) && (nf != '0) && no_ok && vco_ok && out_ok;
  end
endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= '0;
    else if (load)      cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
  import pll_seq_pkg::*;
#(
  parameter int NR_W    = 6,
  parameter int NF_W    = 13,
  parameter int OD_W    = 4,
  parameter int REF_HZ  = 24000000,
  parameter int DEEP_HZ = 32768
) (
  input  logic            clk,
  input  logic            rst,
  input  pll_mode_e       mode,
  input  logic [NR_W-1:0] nr_m1,
  input  logic [NF_W-1:0] nf_m1,
  input  logic [OD_W-1:0] no_m1,
  output logic [31:0]     rate_hz
);
  logic [63:0] num, den, quo;

  always_comb begin
    num = 64'(REF_HZ) * (64'(nf_m1) + 64'd1);
    den = (64'(nr_m1) + 64'd1) * (64'(no_m1) + 64'd1);
    quo = num / den;
  end

  always_ff @(posedge clk) begin
    if (rst) rate_hz <= 32'(REF_HZ);
    else begin
      case (mode)
        MODE_NORMAL: rate_hz <= quo[31:0];
        MODE_DEEP:   rate_hz <= 32'(DEEP_HZ);
        default:     rate_hz <= 32'(REF_HZ);
      endcase
    end
  end
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int CLK_HZ     = 200000000,
  parameter int REF_HZ     = 24000000,
  parameter int NR_W       = 6,
  parameter int NF_W       = 13,
  parameter int OD_W       = 4,
  parameter int LOCK_POLLS = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [NR_W-1:0]   req_nr,
  input  logic [NF_W-1:0]   req_nf,
  input  logic [OD_W:0]     req_no,
  input  logic              deep_en,
  input  logic              pll_lock,
  output logic              busy,
  output logic              done,
  output logic              err_reject,
  output logic              err_timeout,
  output logic [1:0]        pll_mode,
  output logic              pll_reset,
  output logic [NR_W-1:0]   cfg_nr_m1,
  output logic [NF_W-1:0]   cfg_nf_m1,
  output logic [OD_W-1:0]   cfg_no_m1,
  output logic [NF_W-2:0]   cfg_bwadj,
  output logic [31:0]       rate_hz
);
  localparam int SETTLE_CYC = CLK_HZ / 100000;
  localparam int POLL_CYC   = CLK_HZ / 1000000;
  localparam int TMR_W      = $clog2(SETTLE_CYC + 1);
  localparam int PC_W       = $clog2(LOCK_POLLS + 1);

  seq_state_e        state_q;
  pll_mode_e         mode_q;
  logic [NR_W-1:0]   nr_q;
  logic [NF_W-1:0]   nf_q;
  logic [OD_W:0]     no_q;
  logic [PC_W-1:0]   poll_cnt_q;
  logic              req_ok, tmr_zero, tmr_load;
  logic [TMR_W-1:0]  tmr_val;

  pll_req_check #(.NR_W(NR_W), .NF_W(NF_W), .OD_W(OD_W), .REF_KHZ(REF_HZ / 1000))
    u_check (.nr(req_nr), .nf(req_nf), .no(req_no), .ok(req_ok));

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = TMR_W'(POLL_CYC - 1);
    if (state_q == ST_LOAD) begin
      tmr_load = 1'b1;
      tmr_val  = TMR_W'(SETTLE_CYC - 1);
    end else if ((state_q == ST_SETTLE || state_q == ST_POLL) && tmr_zero) begin
      tmr_load = 1'b1;
    end
  end

  pll_seq_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      mode_q      <= MODE_SLOW;
      busy        <= 1'b0;
      done        <= 1'b0;
      err_reject  <= 1'b0;
      err_timeout <= 1'b0;
      pll_reset   <= 1'b0;
      nr_q        <= '0;
      nf_q        <= '0;
      no_q        <= '0;
      poll_cnt_q  <= '0;
      cfg_nr_m1   <= '0;
      cfg_nf_m1   <= '0;
      cfg_no_m1   <= '0;
      cfg_bwadj   <= '0;
    end else begin
      done        <= 1'b0;
      err_reject  <= 1'b0;
      err_timeout <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            if (req_ok) begin
              nr_q    <= req_nr;
              nf_q    <= req_nf;
              no_q    <= req_no;
              mode_q  <= MODE_SLOW;
              busy    <= 1'b1;
              state_q <= ST_RST;
            end else begin
              done       <= 1'b1;
              err_reject <= 1'b1;
            end
          end else if (deep_en) begin
            mode_q <= MODE_DEEP;
          end else if (mode_q == MODE_DEEP) begin
            mode_q <= MODE_SLOW;
          end
        end
        ST_RST: begin
          pll_reset <= 1'b1;
          state_q   <= ST_LOAD;
        end
        ST_LOAD: begin
          cfg_nr_m1 <= nr_q - 1'b1;
          cfg_nf_m1 <= nf_q - 1'b1;
          cfg_no_m1 <= OD_W'(no_q - 1'b1);
          cfg_bwadj <= nf_q[NF_W-1:1] - 1'b1;
          state_q   <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (tmr_zero) begin
            pll_reset  <= 1'b0;
            poll_cnt_q <= '0;
            state_q    <= ST_POLL;
          end
        end
        ST_POLL: begin
          if (tmr_zero) begin
            if (pll_lock) begin
              mode_q  <= MODE_NORMAL;
              busy    <= 1'b0;
              done    <= 1'b1;
              state_q <= ST_IDLE;
            end else if (poll_cnt_q == PC_W'(LOCK_POLLS - 1)) begin
              busy        <= 1'b0;
              done        <= 1'b1;
              err_timeout <= 1'b1;
              state_q     <= ST_IDLE;
            end else begin
              poll_cnt_q <= poll_cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pll_mode = mode_q;

  pll_rate_calc #(.NR_W(NR_W), .NF_W(NF_W), .OD_W(OD_W), .REF_HZ(REF_HZ)) u_rate (
    .clk(clk), .rst(rst), .mode(mode_q), .nr_m1(cfg_nr_m1), .nf_m1(cfg_nf_m1),
    .no_m1(cfg_no_m1), .rate_hz(rate_hz));

  // Cycle count of the reset window, kept only for the settle assertion.
  logic [TMR_W:0] hold_cnt_q;
  always_ff @(posedge clk) begin
    if (rst)            hold_cnt_q <= '0;
    else if (pll_reset) hold_cnt_q <= hold_cnt_q + 1'b1;
    else                hold_cnt_q <= '0;
  end

  // R5
  settle_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_reset) |-> hold_cnt_q == (TMR_W+1)'(SETTLE_CYC + 1));

  // R6
  normal_after_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_NORMAL && $past(mode_q) != MODE_NORMAL) |-> $past(pll_lock));

  // R4
  image_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_nf_m1) |-> pll_reset);

  // R3
  reset_in_slow_chk: assert property (@(posedge clk) disable iff (rst)
    pll_reset |-> (busy && mode_q == MODE_SLOW));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
endmodule

// File: tb/pll_reprog_seq_tb.sv
module pll_reprog_seq_tb;
  localparam int CLK_HZ = 10000000;
  localparam int LP     = 8;
  localparam int S      = CLK_HZ / 100000;
  localparam int P      = CLK_HZ / 1000000;
  localparam longint REF = 24000000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [5:0]  req_nr = '0;
  logic [12:0] req_nf = '0;
  logic [4:0]  req_no = '0;
  logic deep_en = 1'b0;
  logic pll_lock = 1'b0;
  logic busy, done, err_reject, err_timeout, pll_reset;
  logic [1:0] pll_mode;
  logic [5:0] cfg_nr_m1;
  logic [12:0] cfg_nf_m1;
  logic [3:0] cfg_no_m1;
  logic [11:0] cfg_bwadj;
  logic [31:0] rate_hz;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pll_reprog_seq #(.CLK_HZ(CLK_HZ), .LOCK_POLLS(LP)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_nr(req_nr), .req_nf(req_nf),
    .req_no(req_no), .deep_en(deep_en), .pll_lock(pll_lock), .busy(busy), .done(done),
    .err_reject(err_reject), .err_timeout(err_timeout), .pll_mode(pll_mode),
    .pll_reset(pll_reset), .cfg_nr_m1(cfg_nr_m1), .cfg_nf_m1(cfg_nf_m1),
    .cfg_no_m1(cfg_no_m1), .cfg_bwadj(cfg_bwadj), .rate_hz(rate_hz));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit legal(int nr, int nf, int no);
    longint v = 24000 * longint'(nf);
    if (nr == 0 || nf == 0 || no == 0 || no > 16) return 0;
    if (no != 1 && (no % 2) != 0) return 0;
    if (v < 440000 * longint'(nr) || v > 2200000 * longint'(nr)) return 0;
    if (v < 27500 * longint'(nr) * longint'(no)) return 0;
    return 1;
  endfunction

  task automatic do_req(input int nr, input int nf, input int no, input int lock_at);
    bit ok = legal(nr, nf, no);
    logic [1:0] m0 = pll_mode;
    logic [12:0] f0 = cfg_nf_m1;
    int hi, k, expk;
    @(negedge clk);
    req_nr = 6'(nr); req_nf = 13'(nf); req_no = 5'(no); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (!ok) begin
      chk(done && err_reject && !busy, "R2 reject flags", {done, err_reject, busy}, 3'b110);
      chk(pll_mode == m0 && cfg_nf_m1 == f0 && !pll_reset, "R2 no change", pll_mode, m0);
      return;
    end
    chk(busy && pll_mode == 2'd0 && !pll_reset && !done, "R3 accept", {busy, pll_mode}, 3'b100);
    @(negedge clk);
    chk(pll_reset == 1'b1, "R3 reset rises", pll_reset, 1);
    hi = 1;
    while (hi < 10000) begin
      @(negedge clk);
      if (!pll_reset) break;
      hi++;
      if (hi == 2) begin
        chk(cfg_nr_m1 == 6'(nr - 1) && cfg_nf_m1 == 13'(nf - 1) && cfg_no_m1 == 4'(no - 1),
            "R4 fields", {cfg_nr_m1, cfg_nf_m1, cfg_no_m1}, {6'(nr-1), 13'(nf-1), 4'(no-1)});
        chk(cfg_bwadj == 12'((nf >> 1) - 1), "R4 bwadj", cfg_bwadj, (nf >> 1) - 1);
      end
    end
    chk(hi == S + 1, "R5 settle length", hi, S + 1);
    k = 0;
    if (lock_at == 0) pll_lock = 1'b1;
    while (k < 5000) begin
      @(negedge clk);
      k++;
      if (done) break;
      if (k == lock_at) pll_lock = 1'b1;
    end
    if (lock_at >= 0) begin
      expk = ((lock_at + P) / P) * P;
      chk(k == expk && pll_mode == 2'd1 && !err_timeout && !busy, "R6 lock done", k, expk);
    end else begin
      chk(k == P * LP && err_timeout && pll_mode == 2'd0 && !busy, "R7 timeout", k, P * LP);
    end
    pll_lock = 1'b0;
    @(negedge clk);
    if (lock_at >= 0)
      chk(longint'(rate_hz) == REF * nf / (nr * no), "R9 normal rate", rate_hz, REF * nf / (nr * no));
    else
      chk(longint'(rate_hz) == REF, "R9 slow rate", rate_hz, REF);
  endtask

  initial begin
    int nrs[4] = '{1, 2, 3, 7};
    int nfs[9] = '{5, 18, 19, 37, 46, 92, 183, 184, 400};
    int nos[8] = '{0, 1, 2, 3, 4, 6, 16, 17};
    repeat (3) @(negedge clk);
    chk(pll_mode == 2'd0 && !pll_reset && !busy && !done && longint'(rate_hz) == REF,
        "R1 in reset", rate_hz, REF);
    rst = 1'b0;
    @(negedge clk);
    chk(pll_mode == 2'd0 && !busy && !err_reject && !err_timeout && longint'(rate_hz) == REF,
        "R1 after reset", {pll_mode, busy}, 0);

    // Boundaries of the legal range
    do_req(6, 110, 1, 0);
    do_req(6, 109, 1, 0);
    do_req(6, 550, 2, 3);
    do_req(6, 551, 2, 3);
    do_req(3, 55, 16, 9);
    do_req(0, 100, 2, 0);
    do_req(1, 0, 2, 0);
    do_req(2, 37, 16, 1);

    // Sweep of a small grid
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 9; b++)
        for (int c = 0; c < 8; c++)
          do_req(nrs[a], nfs[b], nos[c], (nrs[a] + nfs[b] + nos[c]) % 23);

    // R7: lock never comes
    do_req(1, 50, 2, -1);

    // R10: deep entry and exit
    @(negedge clk);
    deep_en = 1'b1;
    @(negedge clk);
    chk(pll_mode == 2'd2, "R10 deep entry", pll_mode, 2);
    @(negedge clk);
    chk(longint'(rate_hz) == 32768, "R9 deep rate", rate_hz, 32768);
    deep_en = 1'b0;
    @(negedge clk);
    chk(pll_mode == 2'd0, "R10 deep exit", pll_mode, 0);
    deep_en = 1'b1;
    repeat (2) @(negedge clk);
    deep_en = 1'b0;
    do_req(2, 100, 2, 4);
    chk(pll_mode == 2'd1, "R10 request from deep", pll_mode, 1);

    // R8: requests while busy are ignored
    @(negedge clk);
    req_nr = 6'd1; req_nf = 13'd50; req_no = 5'd2; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      req_nr = 6'd2; req_nf = 13'd100; req_no = 5'd4; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    pll_lock = 1'b1;
    for (int i = 0; i < 1000 && !done; i++) @(negedge clk);
    pll_lock = 1'b0;
    chk(done && cfg_nr_m1 == 6'd0 && cfg_nf_m1 == 13'd49 && cfg_no_m1 == 4'd1,
        "R8 busy requests ignored", cfg_nf_m1, 49);
    repeat (2) @(negedge clk);
    chk(!busy && longint'(rate_hz) == REF * 50 / 2, "R8 rate after ignore", rate_hz, REF * 25);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule